// File: doc/BRIEF.md
# Receive Clock-Compensation FIFO

This block sits on the receive side of a serial link. Words arrive on a recovered write clock and leave on a local read clock. In clock-compensation mode each entry is a 64-bit word with a control flag and a two-bit kind code. The block keeps its fill level away from both ends by editing the stream:

- When the FIFO is filling, it drops an idle or ordered-set word.
- When the FIFO is draining, it emits an extra idle word.

This lets the block absorb a frequency offset of ±100 ppm between the two clocks.

In generic mode, words pass through untouched. The reader gets a partially-empty flag and a full flag, so it can throttle its reads. The partially-empty level is held in a loadable register.

In phase-compensation mode, the block is a plain dual-clock FIFO. It neither adds nor drops words, and it reports no flags.

The block is 32 entries deep. The write and read pointers cross between the clock domains as Gray codes through two-flop synchronizers. The mode is static: it changes only while both resets are held.

Top module: `rx_rate_fifo`

## Requirements
- R1: After reset in generic mode, `rd_valid` is 0, `rd_part_empty` is 1 and `rd_full` is 0.
- R2: `wr_kind`/`rd_kind` encode each word as follows:

  | Code | Kind |
  |------|------|
  | 0 | data |
  | 1 | idle |
  | 2 | ordered set |
  | 3 | other control |

  A word may be deleted only if `wr_ctrl`=1 and its kind is 1 or 2. Data and other-control words always reach the output.
- R3: In clock-compensation mode (`mode`=2), a deletable word offered while the write-side occupancy is 24 or more is dropped. Two consecutive offered words are never both dropped. Both idles and ordered sets can be dropped.
- R4: In clock-compensation mode, a read while the read-side occupancy is 8 or less emits an inserted idle instead of popping. An inserted idle has `rd_kind`=1, `rd_ctrl`=1 and every byte lane of `rd_data` equal to 0x07. Two inserted idles are never consecutive unless the FIFO is empty.
- R5: In clock-compensation mode, every `rd_en` gives `rd_valid`=1 on the following read clock. A read of an empty FIFO returns an inserted idle.
- R6: In clock-compensation mode, the words that reach the output keep their write order. No ordered set is ever created: the output contains no more ordered sets than were written.
- R7: In generic mode (`mode`=1), no word is added or dropped. A read of an empty FIFO gives `rd_valid`=0. A write to a full FIFO (32 words) is discarded.
- R8: In generic mode:
  - `rd_part_empty`=1 exactly when the read-side occupancy is at or below the threshold.
  - `rd_full`=1 exactly when the occupancy is 32.
- R9: The partially-empty threshold resets to 4. A cycle with `pe_load`=1 loads it from `pe_value`.
- R10: In phase-compensation mode (`mode`=0 or 3):
  - Words pass unchanged and in order.
  - No word is ever inserted.
  - `rd_part_empty` and `rd_full` stay 0.
- R11: In clock-compensation mode, a write/read rate mismatch of one word in eight, in either direction, loses no data word. This is far beyond ±100 ppm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| mode | input | 2 | 0/3 phase compensation, 1 generic, 2 clock compensation |
| wr_valid | input | 1 | A word is offered this write clock |
| wr_data | input | 64 | Offered word payload |
| wr_ctrl | input | 1 | Offered word is a control word |
| wr_kind | input | 2 | Offered word kind (R2) |
| rd_en | input | 1 | Reader requests one word |
| rd_valid | output | 1 | Output word valid, one read clock after `rd_en` |
| rd_data | output | 64 | Output word payload |
| rd_ctrl | output | 1 | Output word control flag |
| rd_kind | output | 2 | Output word kind |
| rd_part_empty | output | 1 | Occupancy at or below threshold (generic mode) |
| rd_full | output | 1 | Occupancy equals depth (generic mode) |
| pe_load | input | 1 | Load the partially-empty threshold |
| pe_value | input | 6 | New partially-empty threshold |

## Verification
Deletion on the write side and popping on the read side can fall in the same cycle. The deletion decision then uses an occupancy that the synchronizer delay has made stale. The fill scenarios provoke this by writing every cycle while the reader pulls seven cycles in eight, so the level sits at the deletion threshold while both ends move. The result is judged against an ordered list of the written words: every data and other-control word must appear exactly once and in order, and only ordered sets may be skipped. Insertion likewise coincides with incoming writes in the drain scenario, and is judged by the idle pattern and by all data still arriving.

// File: rtl/rx_rate_fifo.sv
module rx_rate_fifo #(
  parameter int DW         = 64,
  parameter int AW         = 5,
  parameter int DEL_AT     = 24,
  parameter int INS_AT     = 8,
  parameter int PE_DEFAULT = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic [1:0]    mode,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_ctrl,
  input  logic [1:0]    wr_kind,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_ctrl,
  output logic [1:0]    rd_kind,
  output logic          rd_part_empty,
  output logic          rd_full,
  input  logic          pe_load,
  input  logic [AW:0]   pe_value
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int EW    = DW + 3;
  localparam logic [1:0] K_IDLE = 2'd1;
  localparam logic [1:0] K_OSET = 2'd2;
  localparam logic [DW-1:0] IDLE_WORD = {(DW/8){8'h07}};

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic mode_cc, mode_gen;
  assign mode_cc  = (mode == 2'd2);
  assign mode_gen = (mode == 2'd1);

  logic [EW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, wocc, wbin_nx;
  logic [PW-1:0] rgray;
  logic          del_last, w_del_ok, wfull, w_drop, w_push;

  assign wocc     = wbin - g2b(rg_s2);
  assign wfull    = (wocc == PW'(DEPTH));
  assign w_del_ok = wr_ctrl && (wr_kind == K_IDLE || wr_kind == K_OSET);
  assign w_drop   = mode_cc && wr_valid && w_del_ok && (wocc >= PW'(DEL_AT)) && !del_last;
  assign w_push   = wr_valid && !wfull && !w_drop;
  assign wbin_nx  = wbin + PW'(w_push);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      del_last <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= b2g(wbin_nx);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_valid) del_last <= w_drop;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (w_push) mem[wbin[AW-1:0]] <= {wr_kind, wr_ctrl, wr_data};
  end

  // read domain
  logic [PW-1:0] rbin, wg_s1, wg_s2, rocc, rbin_nx, pe_level;
  logic          ins_last, rempty, r_ins, r_pop;
  logic [EW-1:0] head;

  assign rocc    = g2b(wg_s2) - rbin;
  assign rempty  = (rocc == '0);
  assign r_ins   = mode_cc && rd_en && (rempty || (rocc <= PW'(INS_AT) && !ins_last));
  assign r_pop   = rd_en && !rempty && !r_ins;
  assign rbin_nx = rbin + PW'(r_pop);
  assign head    = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      ins_last <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_ctrl  <= 1'b0;
      rd_kind  <= '0;
      pe_level <= PW'(PE_DEFAULT);
    end else begin
      rbin     <= rbin_nx;
      rgray    <= b2g(rbin_nx);
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      rd_valid <= r_pop || r_ins;
      if (rd_en) ins_last <= r_ins;
      if (r_ins)      {rd_kind, rd_ctrl, rd_data} <= {K_IDLE, 1'b1, IDLE_WORD};
      else if (r_pop) {rd_kind, rd_ctrl, rd_data} <= head;
      if (pe_load) pe_level <= pe_value;
    end
  end

  assign rd_part_empty = mode_gen && (rocc <= pe_level);
  assign rd_full       = mode_gen && (rocc == PW'(DEPTH));

  // R7: neither side ever sees more than DEPTH words
  p_wocc_bound_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wocc <= PW'(DEPTH)) else $error("write-side occupancy above depth");
  p_rocc_bound_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rocc <= PW'(DEPTH)) else $error("read-side occupancy above depth");

  // R3: a word skipped while room existed was deletable and the level was high
  p_del_kind_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (mode_cc && $past(wr_valid) && !$past(wfull) && wbin == $past(wbin))
    |-> ($past(wr_ctrl) && ($past(wr_kind) == K_IDLE || $past(wr_kind) == K_OSET)
         && $past(wocc) >= PW'(DEL_AT)))
    else $error("non-deletable word dropped");

  // R7: outside compensation every accepted offer advances the write pointer
  p_no_drop_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!mode_cc && $past(wr_valid) && !$past(wfull)) |-> (wbin == $past(wbin) + PW'(1)))
    else $error("word lost outside compensation mode");

  // R4: a read that did not pop shows the idle pattern
  p_ins_idle_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (mode_cc && $past(rd_en) && rbin == $past(rbin))
    |-> (rd_valid && rd_ctrl && rd_kind == K_IDLE && rd_data == IDLE_WORD))
    else $error("inserted word is not an idle");

  // R5: compensation mode answers every read
  p_cc_valid_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (mode_cc && $past(rd_en)) |-> rd_valid) else $error("read left unanswered");

  // R10: outside compensation every output word is a real pop
  p_pass_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!mode_cc && rd_valid) |-> (rbin == $past(rbin) + PW'(1)))
    else $error("word inserted outside compensation mode");
endmodule

// File: tb/tb_rx_rate_fifo.sv
`timescale 1ns/1ps
module tb_rx_rate_fifo;
  localparam logic [1:0] M_PHASE = 2'd0, M_GEN = 2'd1, M_CC = 2'd2;
  localparam logic [1:0] K_DATA = 2'd0, K_IDLE = 2'd1, K_OSET = 2'd2, K_OTHER = 2'd3;
  localparam logic [63:0] IDLE_WORD = {8{8'h07}};
  typedef logic [66:0] word_t;

  logic wr_clk, wr_rst_n, rd_clk, rd_rst_n;
  logic [1:0] mode;
  logic wr_valid, wr_ctrl, rd_en, pe_load;
  logic [63:0] wr_data;
  logic [1:0] wr_kind;
  logic rd_valid, rd_ctrl, rd_part_empty, rd_full;
  logic [63:0] rd_data;
  logic [1:0] rd_kind;
  logic [5:0] pe_value;

  rx_rate_fifo dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .mode(mode), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wr_kind(wr_kind), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ctrl(rd_ctrl), .rd_kind(rd_kind), .rd_part_empty(rd_part_empty),
    .rd_full(rd_full), .pe_load(pe_load), .pe_value(pe_value)
  );

  initial wr_clk = 1'b0;
  always #4 wr_clk = ~wr_clk;
  initial begin
    rd_clk = 1'b0;
    #3;
    forever #4 rd_clk = ~rd_clk;
  end

  int n_vec = 0, n_bad = 0;
  word_t q[$];
  bit exact, wr_done;
  int err_cnt, idle_in, idle_out, os_in, os_out, oth_in, oth_out, valid_cnt, miss_valid;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic word_t pick(input int pat, input int i);
    int s;
    s = (pat == 0) ? i % 6 : (pat == 1) ? ((i % 3 == 0) ? 0 : 4) :
        (pat == 2) ? ((i % 3 == 2) ? 2 : 0) : ((i % 4) * 2 - ((i % 4 == 3) ? 1 : 0));
    case (s)
      0, 1:    return {K_DATA, 1'b0, 32'hDA7A0000, 32'(i)};
      2, 3:    return {K_IDLE, 1'b1, IDLE_WORD};
      4:       return {K_OSET, 1'b1, 8'h9C, 24'h0, 32'(i)};
      default: return {K_OTHER, 1'b1, 8'hFE, 24'h0, 32'(i)};
    endcase
  endfunction

  task automatic reset_dut(input logic [1:0] m);
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wr_ctrl = 1'b0; wr_kind = '0;
    rd_en = 1'b0; pe_load = 1'b0; pe_value = '0; mode = m;
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic take(input word_t w);
    word_t f;
    bit matched, bad;
    valid_cnt++;
    if (exact) begin
      if (q.size() == 0) err_cnt++;
      else begin
        f = q.pop_front();
        if (f !== w) err_cnt++;
      end
    end else if (w[66:65] == K_IDLE) begin
      idle_out++;
      if (w !== {K_IDLE, 1'b1, IDLE_WORD}) err_cnt++;
    end else begin
      if (w[66:65] == K_OSET) os_out++;
      if (w[66:65] == K_OTHER) oth_out++;
      matched = 1'b0; bad = 1'b0;
      while (!matched && !bad && q.size() > 0) begin
        f = q.pop_front();
        if (f === w) matched = 1'b1;
        else if (f[66:65] != K_OSET) bad = 1'b1;
      end
      if (!matched) err_cnt++;
    end
  endtask

  task automatic writer(input int n, input int duty, input int pat);
    int sent = 0;
    int c = 0;
    word_t w;
    while (sent < n) begin
      @(negedge wr_clk);
      if ((c % 8) < duty) begin
        w = pick(pat, sent);
        wr_valid = 1'b1;
        {wr_kind, wr_ctrl, wr_data} = w;
        if (exact || w[66:65] != K_IDLE) q.push_back(w);
        if (w[66:65] == K_IDLE) idle_in++;
        if (w[66:65] == K_OSET) os_in++;
        if (w[66:65] == K_OTHER) oth_in++;
        sent++;
      end else wr_valid = 1'b0;
      c++;
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
    wr_done = 1'b1;
  endtask

  task automatic reader(input int duty);
    int c = 0;
    int tail = 0;
    bit pend = 1'b0;
    while (tail < 60) begin
      @(negedge rd_clk);
      if (rd_valid) take({rd_kind, rd_ctrl, rd_data});
      if (pend && !rd_valid) miss_valid++;
      rd_en = wr_done ? 1'b1 : ((c % 8) < duty);
      pend = rd_en;
      if (wr_done) tail++;
      c++;
    end
    @(negedge rd_clk);
    if (rd_valid) take({rd_kind, rd_ctrl, rd_data});
    rd_en = 1'b0;
    @(negedge rd_clk);
  endtask

  task automatic run_stream(input logic [1:0] m, input int n, input int wduty, input int rduty, input int pat);
    reset_dut(m);
    q.delete();
    exact = (m != M_CC);
    wr_done = 1'b0;
    err_cnt = 0; idle_in = 0; idle_out = 0; os_in = 0; os_out = 0;
    oth_in = 0; oth_out = 0; valid_cnt = 0; miss_valid = 0;
    fork
      writer(n, wduty, pat);
      reader(rduty);
    join
  endtask

  task automatic write_words(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_kind = K_DATA; wr_ctrl = 1'b0;
      wr_data = {32'hDA7A0000, 32'(base + i)};
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut(M_GEN);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", 64'(rd_valid), 0);
    check(rd_part_empty == 1'b1, "R1 part_empty after reset", 64'(rd_part_empty), 1);
    check(rd_full == 1'b0, "R1 full after reset", 64'(rd_full), 0);
  endtask

  task automatic t_cc_empty();
    reset_dut(M_CC);
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk);
      check(rd_valid && rd_ctrl && rd_kind == K_IDLE && rd_data == IDLE_WORD,
            "R5 R4 empty read gives idle", rd_data, IDLE_WORD);
    end
    rd_en = 1'b0;
  endtask

  task automatic t_cc_fill();
    run_stream(M_CC, 4000, 8, 7, 0);
    check(err_cnt == 0, "R6 order kept while filling", 64'(err_cnt), 0);
    check(q.size() == 0, "R11 no data lost while filling", 64'(q.size()), 0);
    check(idle_out < idle_in, "R3 idles deleted while filling", 64'(idle_out), 64'(idle_in));
    check(os_out <= os_in, "R6 no ordered set invented", 64'(os_out), 64'(os_in));
    check(oth_out == oth_in, "R2 other-control words never deleted", 64'(oth_out), 64'(oth_in));
    check(miss_valid == 0, "R5 every read answered", 64'(miss_valid), 0);
  endtask

  task automatic t_cc_oset();
    run_stream(M_CC, 3000, 8, 7, 1);
    check(err_cnt == 0, "R6 order kept with ordered sets", 64'(err_cnt), 0);
    check(q.size() == 0, "R11 no data lost with ordered sets", 64'(q.size()), 0);
    check(os_out < os_in, "R3 ordered sets deleted", 64'(os_out), 64'(os_in));
  endtask

  task automatic t_cc_drain();
    run_stream(M_CC, 3000, 7, 8, 2);
    check(err_cnt == 0, "R6 order kept while draining", 64'(err_cnt), 0);
    check(q.size() == 0, "R11 no data lost while draining", 64'(q.size()), 0);
    check(idle_out > idle_in, "R4 idles inserted while draining", 64'(idle_out), 64'(idle_in));
    check(miss_valid == 0, "R5 every read answered while draining", 64'(miss_valid), 0);
  endtask

  task automatic t_gen_stream();
    run_stream(M_GEN, 400, 4, 7, 3);
    check(err_cnt == 0, "R7 generic stream unchanged", 64'(err_cnt), 0);
    check(valid_cnt == 400, "R7 generic word count", 64'(valid_cnt), 400);
  endtask

  task automatic t_gen_flags();
    int cnt = 0;
    int seq_err = 0;
    reset_dut(M_GEN);
    write_words(4, 0);
    repeat (8) @(negedge rd_clk);
    check(rd_part_empty == 1'b1, "R9 R8 default threshold, occupancy 4", 64'(rd_part_empty), 1);
    write_words(1, 4);
    repeat (8) @(negedge rd_clk);
    check(rd_part_empty == 1'b0, "R9 R8 default threshold, occupancy 5", 64'(rd_part_empty), 0);
    pe_load = 1'b1; pe_value = 6'd10;
    @(negedge rd_clk);
    pe_load = 1'b0;
    check(rd_part_empty == 1'b1, "R9 loaded threshold 10, occupancy 5", 64'(rd_part_empty), 1);
    write_words(28, 5);
    repeat (8) @(negedge rd_clk);
    check(rd_full == 1'b1, "R8 full at 32", 64'(rd_full), 1);
    check(rd_part_empty == 1'b0, "R8 part_empty low at 32", 64'(rd_part_empty), 0);
    rd_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge rd_clk);
      if (rd_valid) begin
        if (rd_data[31:0] != 32'(cnt)) seq_err++;
        cnt++;
      end
    end
    check(rd_valid == 1'b0, "R7 empty read gives no word", 64'(rd_valid), 0);
    rd_en = 1'b0;
    check(cnt == 32, "R7 write to full discarded", 64'(cnt), 32);
    check(seq_err == 0, "R7 generic order", 64'(seq_err), 0);
    check(rd_full == 1'b0, "R8 full clears when empty", 64'(rd_full), 0);
  endtask

  task automatic t_phase();
    reset_dut(M_PHASE);
    check(rd_part_empty == 1'b0, "R10 part_empty held low", 64'(rd_part_empty), 0);
    write_words(40, 0);
    repeat (8) @(negedge rd_clk);
    check(rd_full == 1'b0, "R10 full held low", 64'(rd_full), 0);
    run_stream(M_PHASE, 400, 4, 7, 3);
    check(err_cnt == 0, "R10 phase stream unchanged", 64'(err_cnt), 0);
    check(valid_cnt == 400, "R10 phase word count, nothing inserted", 64'(valid_cnt), 400);
  endtask

  initial begin
    repeat (190000) @(posedge wr_clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cc_empty();
    t_cc_fill();
    t_cc_oset();
    t_cc_drain();
    t_gen_stream();
    t_gen_flags();
    t_phase();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule